// File: doc/BRIEF.md
# Dual-Clock Mailbox Register

This block passes a single word from a writing port to a reading port that runs on an unrelated clock, without going through a queue. A write that is correctly qualified stores the word and marks the mailbox as holding unread mail. Further writes are then refused until the reader has taken the word. The reader consumes the word with a qualified read, and the mailbox becomes free again.

Each side sees its own copy of an active-low "mail present" flag in its own clock domain. The set and clear events cross between the domains as toggles through two-flop synchronizers, so each side's view of the other side's action lags by a couple of its own clocks. The stored word stays stable from the write until the writer sees the clear, so the reader never samples a changing value.

Two resets are provided, and either one empties the mailbox. The full reset also captures the width mode. In narrow mode only the low half of the word is kept. The partial reset keeps the width mode as it was.

Top module: `mbx_mailbox`

## Requirements
- R1: A write is accepted on a rising `wr_clk` edge only when `wr_cs_n`=0, `wr_en`=1, `wr_dir`=1 (1 means write), `wr_mb_sel`=1 and `wr_mail_full_n`=1. Any other combination stores nothing, and both flags stay high.
- R2: After an accepted write edge, `wr_mail_full_n` is low.
- R3: While `wr_mail_full_n` is low, write attempts are ignored and the stored word does not change.
- R4: After an accepted write, `rd_mail_full_n` is still high right after the write edge. It is low by the third falling `rd_clk` edge.
- R5: While `rd_mail_full_n` is low, `rd_data` holds the accepted word and does not change. In narrow mode, bits [DATA_W-1:DATA_W/2] read as zero.
- R6: A rising `rd_clk` edge with `rd_ren`=1, `rd_mb_sel`=1 and `rd_mail_full_n`=0 sets `rd_mail_full_n` high. `wr_mail_full_n` returns high within four `wr_clk` cycles after that.
- R7: A qualified read while `rd_mail_full_n` is high has no effect. Both flags stay high, and the next write is delivered normally.
- R8: Asserting `mrst_n` or `prst_n` low drives both flags high and `rd_data` to zero at once, without waiting for a clock edge.
- R9: The width mode is sampled from `cfg_byte` (1 = narrow) while `mrst_n` is low. A partial reset keeps it.
- R10: A read with `rd_mb_sel`=0 does not consume the mail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Full reset, active low, asynchronous |
| prst_n | input | 1 | Partial reset, active low, asynchronous; keeps width mode |
| cfg_byte | input | 1 | Width mode sampled during full reset (1 = narrow) |
| wr_cs_n | input | 1 | Write-port chip select, active low |
| wr_en | input | 1 | Write-port enable |
| wr_dir | input | 1 | Direction, 1 = write |
| wr_mb_sel | input | 1 | Mailbox select on the write port |
| wr_data | input | DATA_W | Word to store |
| wr_mail_full_n | output | 1 | Mail-present flag in the write domain, active low |
| rd_ren | input | 1 | Read enable |
| rd_mb_sel | input | 1 | Mailbox select on the read port |
| rd_data | output | DATA_W | Stored word |
| rd_mail_full_n | output | 1 | Mail-present flag in the read domain, active low |

## Verification
The hardest situation to reach from the ports is the window in which the two flags disagree. The reader has already consumed the mail, but the writer still sees the mailbox as full. A write attempt in that window must still be refused.

The bench reaches this window on purpose. It attempts a second write straight after an accepted one, while the clear has not yet crossed. It then polls the write-side flag edge by edge after a read, so that a refused write falls inside the lag. The two clocks have unrelated periods, which makes the relative phase of the edges drift across the vector walk.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic {
    WMODE_WORD = 1'b0,
    WMODE_BYTE = 1'b1
  } wmode_e;

  localparam int MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = d;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_wr_side.sv
module mbx_wr_side
  import mbx_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              en,
  input  logic              dir,
  input  logic              sel,
  input  logic [DATA_W-1:0] data,
  input  wmode_e            wmode,
  input  logic              clr_tgl_async,
  output logic              set_tgl,
  output logic [DATA_W-1:0] word,
  output logic              full_n
);
  localparam int NARROW_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic              clr_seen;
  logic              full;
  logic              accept;
  logic              set_d;
  logic [DATA_W-1:0] word_d;
  logic [DATA_W-1:0] masked;

  mbx_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (clr_tgl_async),
    .q    (clr_seen)
  );

  always_comb begin
    full   = set_tgl ^ clr_seen;
    accept = !cs_n && en && dir && sel && !full;
    masked = (wmode == WMODE_BYTE) ? (data & NARROW_MASK) : data;
    set_d  = set_tgl ^ accept;
    word_d = accept ? masked : word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_tgl <= 1'b0;
      word    <= '0;
    end else begin
      set_tgl <= set_d;
      word    <= word_d;
    end
  end

  assign full_n = !full;
endmodule

// File: rtl/mbx_rd_side.sv
module mbx_rd_side #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ren,
  input  logic sel,
  input  logic set_tgl_async,
  output logic clr_tgl,
  output logic full_n
);
  logic set_seen;
  logic pending;
  logic consume;
  logic clr_d;

  mbx_sync #(.STAGES(SYNC_STAGES)) u_set_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (set_tgl_async),
    .q    (set_seen)
  );

  always_comb begin
    pending = set_seen ^ clr_tgl;
    consume = ren && sel && pending;
    clr_d   = clr_tgl ^ consume;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_tgl <= 1'b0;
    else        clr_tgl <= clr_d;
  end

  assign full_n = !pending;
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              cfg_byte,
  input  logic              wr_cs_n,
  input  logic              wr_en,
  input  logic              wr_dir,
  input  logic              wr_mb_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_mail_full_n,
  input  logic              rd_ren,
  input  logic              rd_mb_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_mail_full_n
);
  logic              any_rst_n;
  logic              wr_rst_sync_n;
  logic              rd_rst_sync_n;
  logic              mrst_wr_sync_n;
  logic              set_tgl;
  logic              clr_tgl;
  logic [DATA_W-1:0] mail_word;
  wmode_e            cfg_mode;
  wmode_e            cfg_mode_d;

  assign any_rst_n = mrst_n & prst_n;

  mbx_sync #(.STAGES(SYNC_STAGES)) u_wr_rst (
    .clk(wr_clk), .rst_n(any_rst_n), .d(1'b1), .q(wr_rst_sync_n)
  );
  mbx_sync #(.STAGES(SYNC_STAGES)) u_rd_rst (
    .clk(rd_clk), .rst_n(any_rst_n), .d(1'b1), .q(rd_rst_sync_n)
  );
  mbx_sync #(.STAGES(SYNC_STAGES)) u_mrst_wr (
    .clk(wr_clk), .rst_n(mrst_n), .d(1'b1), .q(mrst_wr_sync_n)
  );

  // Width mode: captured while the full reset is held, kept otherwise.
  always_comb begin
    cfg_mode_d = mrst_wr_sync_n ? cfg_mode : wmode_e'(cfg_byte);
  end

  always_ff @(posedge wr_clk) begin
    cfg_mode <= cfg_mode_d;
  end

  mbx_wr_side #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_wr (
    .clk          (wr_clk),
    .rst_n        (wr_rst_sync_n),
    .cs_n         (wr_cs_n),
    .en           (wr_en),
    .dir          (wr_dir),
    .sel          (wr_mb_sel),
    .data         (wr_data),
    .wmode        (cfg_mode),
    .clr_tgl_async(clr_tgl),
    .set_tgl      (set_tgl),
    .word         (mail_word),
    .full_n       (wr_mail_full_n)
  );

  mbx_rd_side #(.SYNC_STAGES(SYNC_STAGES)) u_rd (
    .clk          (rd_clk),
    .rst_n        (rd_rst_sync_n),
    .ren          (rd_ren),
    .sel          (rd_mb_sel),
    .set_tgl_async(set_tgl),
    .clr_tgl      (clr_tgl),
    .full_n       (rd_mail_full_n)
  );

  assign rd_data = mail_word;
endmodule

// File: rtl/mbx_mailbox_chk.sv
module mbx_mailbox_chk #(
  parameter int DATA_W = 18
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              wr_rst_sync_n,
  input logic              rd_rst_sync_n,
  input logic              wr_cs_n,
  input logic              wr_en,
  input logic              wr_dir,
  input logic              wr_mb_sel,
  input logic              wr_mail_full_n,
  input logic              rd_ren,
  input logic              rd_mb_sel,
  input logic              rd_mail_full_n,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] mail_word,
  input logic              cfg_mode
);
  localparam int NARROW_W = DATA_W / 2;

  // R2: a qualified write to an empty mailbox leaves the write-side flag low
  p_write_sets_flag_r2: assert property (@(posedge wr_clk) disable iff (!wr_rst_sync_n)
    (!wr_cs_n && wr_en && wr_dir && wr_mb_sel && wr_mail_full_n) |=> !wr_mail_full_n);

  // R3: the stored word holds while the writer sees mail present
  p_word_held_r3: assert property (@(posedge wr_clk) disable iff (!wr_rst_sync_n)
    (!wr_mail_full_n && $past(!wr_mail_full_n)) |-> $stable(mail_word));

  // R5: the reader sees a steady word while its flag is low
  p_rd_data_steady_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_sync_n)
    (!rd_mail_full_n && $past(!rd_mail_full_n)) |-> $stable(rd_data));

  // R5: narrow mode keeps the upper half at zero
  p_narrow_upper_zero_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_sync_n)
    (cfg_mode && !rd_mail_full_n) |-> (rd_data[DATA_W-1:NARROW_W] == '0));

  // R6: a qualified read of present mail clears the read-side flag
  p_read_clears_r6: assert property (@(posedge rd_clk) disable iff (!rd_rst_sync_n)
    (rd_ren && rd_mb_sel && !rd_mail_full_n) |=> rd_mail_full_n);
endmodule

bind mbx_mailbox mbx_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
  .wr_clk        (wr_clk),
  .rd_clk        (rd_clk),
  .wr_rst_sync_n (wr_rst_sync_n),
  .rd_rst_sync_n (rd_rst_sync_n),
  .wr_cs_n       (wr_cs_n),
  .wr_en         (wr_en),
  .wr_dir        (wr_dir),
  .wr_mb_sel     (wr_mb_sel),
  .wr_mail_full_n(wr_mail_full_n),
  .rd_ren        (rd_ren),
  .rd_mb_sel     (rd_mb_sel),
  .rd_mail_full_n(rd_mail_full_n),
  .rd_data       (rd_data),
  .mail_word     (mail_word),
  .cfg_mode      (cfg_mode)
);

// File: tb/mbx_mailbox_bench.sv
module mbx_mailbox_bench;
  localparam int W = 18;

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  logic mrst_n, prst_n, cfg_byte;
  logic wr_cs_n, wr_en, wr_dir, wr_mb_sel;
  logic [W-1:0] wr_data;
  logic wr_mail_full_n, rd_mail_full_n;
  logic rd_ren, rd_mb_sel;
  logic [W-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 wr_clk = ~wr_clk;
  initial begin
    #1;
    forever #3.5 rd_clk = ~rd_clk;
  end

  mbx_mailbox #(.DATA_W(W)) u_mbx_mailbox (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .cfg_byte(cfg_byte), .wr_cs_n(wr_cs_n), .wr_en(wr_en), .wr_dir(wr_dir),
    .wr_mb_sel(wr_mb_sel), .wr_data(wr_data), .wr_mail_full_n(wr_mail_full_n),
    .rd_ren(rd_ren), .rd_mb_sel(rd_mb_sel), .rd_data(rd_data),
    .rd_mail_full_n(rd_mail_full_n)
  );

  // {cs_n, en, dir, sel, expect_accept, data}
  localparam int NV = 8;
  localparam logic [W+4:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 18'h2A5C3},
    {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 18'h11111},
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 18'h22222},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 18'h33333},
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 18'h04444},
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 18'h3FFFF},
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 18'h00001},
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 18'h15A5A}
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_pulse(input logic cs_n, input logic en, input logic dir, input logic sel, input logic [W-1:0] d);
    @(negedge wr_clk);
    wr_cs_n = cs_n; wr_en = en; wr_dir = dir; wr_mb_sel = sel; wr_data = d;
    @(negedge wr_clk);
    wr_cs_n = 1'b1; wr_en = 1'b0; wr_dir = 1'b0; wr_mb_sel = 1'b0;
  endtask

  task automatic rd_pulse(input logic ren, input logic sel);
    @(negedge rd_clk);
    rd_ren = ren; rd_mb_sel = sel;
    @(negedge rd_clk);
    rd_ren = 1'b0; rd_mb_sel = 1'b0;
  endtask

  task automatic wait_rd_low(output int n);
    n = 0;
    while (rd_mail_full_n && n < 6) begin
      @(negedge rd_clk);
      n++;
    end
  endtask

  task automatic wait_wr_high(output int n);
    n = 0;
    while (!wr_mail_full_n && n < 6) begin
      @(negedge wr_clk);
      n++;
    end
  endtask

  task automatic idle_rd(input int k);
    for (int i = 0; i < k; i++) @(negedge rd_clk);
  endtask

  task automatic full_reset(input logic narrow);
    @(negedge wr_clk);
    mrst_n = 1'b0; cfg_byte = narrow;
    repeat (5) @(negedge wr_clk);
    mrst_n = 1'b1;
    repeat (4) @(negedge wr_clk);
    idle_rd(4);
  endtask

  // write, wait for delivery, check data, consume, wait for write side to clear
  task automatic deliver(input string req, input logic [W-1:0] d, input logic [W-1:0] exp);
    int n;
    wr_pulse(1'b0, 1'b1, 1'b1, 1'b1, d);
    wait_rd_low(n);
    check(req, "read flag after write", {31'd0, rd_mail_full_n}, 32'd0);
    check(req, "read data", {14'd0, rd_data}, {14'd0, exp});
    rd_pulse(1'b1, 1'b1);
    wait_wr_high(n);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired before completion (all requirements)");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    mrst_n = 1'b0; prst_n = 1'b1; cfg_byte = 1'b0;
    wr_cs_n = 1'b1; wr_en = 1'b0; wr_dir = 1'b0; wr_mb_sel = 1'b0; wr_data = '0;
    rd_ren = 1'b0; rd_mb_sel = 1'b0;
    repeat (3) @(negedge wr_clk);
    // R8: reset state
    check("R8", "wr flag in reset", {31'd0, wr_mail_full_n}, 32'd1);
    check("R8", "rd flag in reset", {31'd0, rd_mail_full_n}, 32'd1);
    check("R8", "rd data in reset", {14'd0, rd_data}, 32'd0);
    repeat (2) @(negedge wr_clk);
    mrst_n = 1'b1;
    repeat (4) @(negedge wr_clk);
    idle_rd(4);

    // Vector walk: R1, R2, R4, R5, R6
    for (int v = 0; v < NV; v++) begin
      logic [W-1:0] d;
      logic acc;
      d   = VEC[v][W-1:0];
      acc = VEC[v][W];
      wr_pulse(VEC[v][W+4], VEC[v][W+3], VEC[v][W+2], VEC[v][W+1], d);
      check("R1", $sformatf("wr flag vec %0d", v), {31'd0, wr_mail_full_n}, {31'd0, !acc});
      if (acc) begin
        check("R2", "wr flag low after write", {31'd0, wr_mail_full_n}, 32'd0);
        check("R4", "rd flag still high just after write", {31'd0, rd_mail_full_n}, 32'd1);
        wait_rd_low(n);
        check("R4", "rd flag low within 3 rd edges", {31'd0, (n <= 3) && !rd_mail_full_n}, 32'd1);
        check("R5", $sformatf("rd data vec %0d", v), {14'd0, rd_data}, {14'd0, d});
        rd_pulse(1'b1, 1'b1);
        check("R6", "rd flag high after read", {31'd0, rd_mail_full_n}, 32'd1);
        wait_wr_high(n);
        check("R6", "wr flag high within 4 wr cycles", {31'd0, (n <= 4) && wr_mail_full_n}, 32'd1);
      end else begin
        idle_rd(4);
        check("R1", $sformatf("rd flag stays high vec %0d", v), {31'd0, rd_mail_full_n}, 32'd1);
      end
    end

    // R3: second write while full is ignored, including in the clear-lag window
    wr_pulse(1'b0, 1'b1, 1'b1, 1'b1, 18'h0ABCD);
    wr_pulse(1'b0, 1'b1, 1'b1, 1'b1, 18'h35555);
    wait_rd_low(n);
    check("R3", "data unchanged by refused write", {14'd0, rd_data}, 32'h0ABCD);
    // R10: read without mailbox select keeps mail
    rd_pulse(1'b1, 1'b0);
    idle_rd(3);
    check("R10", "mail kept without select", {31'd0, rd_mail_full_n}, 32'd0);
    rd_pulse(1'b1, 1'b1);
    wr_pulse(1'b0, 1'b1, 1'b1, 1'b1, 18'h26262); // lands in the lag window
    wait_wr_high(n);
    idle_rd(4);
    check("R3", "write during clear lag refused", {31'd0, rd_mail_full_n}, 32'd1);

    // R7: read of empty mailbox has no effect
    rd_pulse(1'b1, 1'b1);
    idle_rd(3);
    check("R7", "rd flag high after empty read", {31'd0, rd_mail_full_n}, 32'd1);
    check("R7", "wr flag high after empty read", {31'd0, wr_mail_full_n}, 32'd1);
    deliver("R7", 18'h1C3C3, 18'h1C3C3);

    // R8: partial reset empties a full mailbox asynchronously
    wr_pulse(1'b0, 1'b1, 1'b1, 1'b1, 18'h12345);
    wait_rd_low(n);
    #1.3 prst_n = 1'b0;
    #0.5;
    check("R8", "wr flag on partial reset", {31'd0, wr_mail_full_n}, 32'd1);
    check("R8", "rd flag on partial reset", {31'd0, rd_mail_full_n}, 32'd1);
    check("R8", "rd data on partial reset", {14'd0, rd_data}, 32'd0);
    repeat (3) @(negedge wr_clk);
    prst_n = 1'b1;
    repeat (4) @(negedge wr_clk);
    idle_rd(4);

    // R8: full reset also empties
    wr_pulse(1'b0, 1'b1, 1'b1, 1'b1, 18'h2F0F0);
    wait_rd_low(n);
    #0.7 mrst_n = 1'b0;
    #0.5;
    check("R8", "rd flag on full reset", {31'd0, rd_mail_full_n}, 32'd1);
    repeat (4) @(negedge wr_clk);
    mrst_n = 1'b1;
    repeat (4) @(negedge wr_clk);
    idle_rd(4);

    // R9 / R5: narrow mode captured in full reset, kept through partial reset
    full_reset(1'b1);
    deliver("R9", 18'h3FFFF, 18'h001FF);
    cfg_byte = 1'b0;
    @(negedge wr_clk); prst_n = 1'b0;
    repeat (3) @(negedge wr_clk); prst_n = 1'b1;
    repeat (4) @(negedge wr_clk);
    idle_rd(4);
    deliver("R9", 18'h2AB55, 18'h00155);
    full_reset(1'b0);
    deliver("R9", 18'h2AB55, 18'h2AB55);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule